// File: doc/BRIEF.md
# EEPROM Page Buffer and Write-Cycle Engine

This block sits between the serial-bus protocol decoder of an EEPROM and its storage array. The decoder hands it a word address when a write transaction opens, one strobe per received data byte, and a single-cycle STOP event. The block gathers the bytes of one page in an internal buffer. Only the low offset bits of the address advance, so the write pointer stays inside one page and wraps.

On STOP the block samples the write-protect level. If protection is off and at least one byte arrived, it scans the page buffer once and drives the array write port for every slot that received data. It then holds `busy` through a programmable self-timed write interval. While `busy` is high the decoder withholds acknowledges, and the block ignores everything on its inputs. A protected STOP, or a STOP that follows only an address phase, discards the transaction and leaves the block ready on the next clock.

Top module: `pageCommitEngine`

## Requirements
- R1: While reset (`rstN` low) is applied and on the first cycle after it is released, `busy` and `memWrEn` are 0.
- R2: `addrLoad` opens a transaction. Page = `startAddr[12:5]`, offset = `startAddr[4:0]`. Each `byteValid` stores `byteData` at the current offset, and then only the 5-bit offset increments, wrapping from 31 to 0 while the page bits stay fixed.
- R3: When more than 32 bytes arrive, byte 33 lands in the first slot the transaction used, and so on, so the array receives the later data for those slots.
- R4: After an accepted STOP, slot i (0..31) is checked in the i-th cycle after the STOP edge, counting from 0. `memWrEn` is high in that cycle only if slot i received data, with `memWrAddr = {page, i}` and `memWrData` = the last byte stored in that slot.
- R5: After an accepted STOP, `busy` is high for exactly 32 + WRITE_CYCLES consecutive cycles, starting the cycle after the STOP edge.
- R6: `wpIn` is sampled only in the STOP cycle. Its level while bytes arrive, or after STOP, does not affect the commit.
- R7: If `wpIn` is 1 at STOP, there are no writes and `busy` stays 0. An `addrLoad` on the very next cycle opens a new transaction.
- R8: A STOP in a transaction that received no bytes causes no writes and does not raise `busy`.
- R9: While `busy` is 1, `addrLoad`, `byteValid` and `stopEvent` are ignored.
- R10: Each `addrLoad` clears the record of received slots, including one that restarts an open transaction. `byteValid` with no open transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLoad | input | 1 | Opens a write transaction with `startAddr` |
| startAddr | input | 13 | Starting word address |
| byteValid | input | 1 | One received data byte |
| byteData | input | 8 | Data byte |
| stopEvent | input | 1 | Bus STOP seen, one cycle |
| wpIn | input | 1 | Write-protect level, 1 = protected |
| memWrEn | output | 1 | Array write strobe |
| memWrAddr | output | 13 | Array write address |
| memWrData | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
Inputs change on falling edges and are registered on the next rising edge, called the STOP edge for a STOP. The write strobe for slot i is due in the i-th cycle after the STOP edge, so the bench samples each falling edge after STOP with a cycle index and checks that every write appears at the index equal to its slot. `busy` is due one cycle after the STOP edge and falls 32 + WRITE_CYCLES cycles later. The bench counts high samples from the first falling edge after STOP. For ignored or rejected stimulus, `busy` and the write port are checked at every falling edge for several cycles afterwards.

// File: rtl/pageCommitPkg.sv
package pageCommitPkg;
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic scanReset;
    logic scanStep;
    logic commitActive;
  } ctrlStrobes_t;
endpackage

// File: rtl/pageBufferPath.sv
module pageBufferPath
  import pageCommitPkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic              anyValid,
  output logic              scanLast,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0]     pageBase;
  logic [OFS_W-1:0]      wrOfs;
  logic [OFS_W-1:0]      scanIdx;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageBase  <= '0;
      wrOfs     <= '0;
      validMask <= '0;
    end else if (strb.loadAddr) begin
      pageBase  <= startAddr[ADDR_W-1:OFS_W];
      wrOfs     <= startAddr[OFS_W-1:0];
      validMask <= '0;
    end else if (strb.storeByte) begin
      validMask[wrOfs] <= 1'b1;
      wrOfs            <= wrOfs + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.storeByte) pageBuf[wrOfs] <= byteData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              scanIdx <= '0;
    else if (strb.scanReset) scanIdx <= '0;
    else if (strb.scanStep)  scanIdx <= scanIdx + 1'b1;
  end

  assign anyValid  = |validMask;
  assign scanLast  = (scanIdx == OFS_W'(PAGE_BYTES - 1));
  assign memWrEn   = strb.commitActive && validMask[scanIdx];
  assign memWrAddr = {pageBase, scanIdx};
  assign memWrData = pageBuf[scanIdx];
endmodule

// File: rtl/pageCommitCtrl.sv
module pageCommitCtrl
  import pageCommitPkg::*;
#(
  parameter int WRITE_CYCLES = 625000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         addrLoad,
  input  logic         byteValid,
  input  logic         stopEvent,
  input  logic         wpIn,
  input  logic         anyValid,
  input  logic         scanLast,
  output ctrlStrobes_t strb,
  output logic         busy
);
  localparam int TMR_W = (WRITE_CYCLES > 1) ? $clog2(WRITE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(WRITE_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_COMMIT, ST_WAIT} state_t;
  state_t state, nextState;
  logic [TMR_W-1:0] timer;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (addrLoad) begin
          strb.loadAddr = 1'b1;
          nextState     = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (stopEvent) begin
          if (anyValid && !wpIn) begin
            strb.scanReset = 1'b1;
            nextState      = ST_COMMIT;
          end else begin
            nextState = ST_IDLE;
          end
        end else if (addrLoad) begin
          strb.loadAddr = 1'b1;
        end else if (byteValid) begin
          strb.storeByte = 1'b1;
        end
      end
      ST_COMMIT: begin
        strb.commitActive = 1'b1;
        strb.scanStep     = 1'b1;
        if (scanLast) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (timer == TMR_LAST) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         timer <= '0;
    else if (state == ST_WAIT && nextState == ST_WAIT) timer <= timer + 1'b1;
    else                                               timer <= '0;
  end

  assign busy = (state == ST_COMMIT) || (state == ST_WAIT);
endmodule

// File: rtl/pageCommitEngine.sv
module pageCommitEngine
  import pageCommitPkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 32,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopEvent,
  input  logic              wpIn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              busy
);
  ctrlStrobes_t strb;
  logic anyValid;
  logic scanLast;

  pageCommitCtrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .byteValid(byteValid),
    .stopEvent(stopEvent), .wpIn(wpIn), .anyValid(anyValid),
    .scanLast(scanLast), .strb(strb), .busy(busy)
  );

  pageBufferPath #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .byteData(byteData), .anyValid(anyValid), .scanLast(scanLast),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/pageCommitEngineChk.sv
module pageCommitEngineChk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopEvent,
  input logic              wpIn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic              busy
);
  // R5
  busy_needs_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvent));

  // R7
  busy_needs_unprotected_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !$past(wpIn));

  // R4
  write_inside_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);

  // R4
  write_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |-> ((memWrAddr - $past(memWrAddr)) == ADDR_W'(1)));

  // R7
  protect_no_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvent && wpIn && !busy) |=> !busy);
endmodule

bind pageCommitEngine pageCommitEngineChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .stopEvent(stopEvent), .wpIn(wpIn),
  .memWrEn(memWrEn), .memWrAddr(memWrAddr), .busy(busy)
);

// File: tb/pageCommitEngine_bench.sv
module pageCommitEngine_bench;
  localparam int WC = 40;
  localparam int BUSY_LEN = 32 + WC;

  logic        clk = 1'b0;
  logic        rstN;
  logic        addrLoad = 0, byteValid = 0, stopEvent = 0, wpIn = 0;
  logic [12:0] startAddr = '0;
  logic [7:0]  byteData = '0;
  logic        memWrEn, busy;
  logic [12:0] memWrAddr;
  logic [7:0]  memWrData;

  int nChecks = 0, nFails = 0, cycles = 0;
  logic [12:0] logAddr [64];
  logic [7:0]  logData [64];
  int          logCyc  [64];

  always #4 clk = ~clk;

  pageCommitEngine #(.WRITE_CYCLES(WC)) u_pageCommitEngine (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopEvent(stopEvent),
    .wpIn(wpIn), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic loadAddr(input logic [12:0] a);
    addrLoad = 1; startAddr = a; @(negedge clk); addrLoad = 0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    byteValid = 1; byteData = b; @(negedge clk); byteValid = 0;
  endtask

  task automatic doStop(input logic wpAt, input logic wpAfter, input bit inject,
                        output int busyLen, output int nWr);
    stopEvent = 1; wpIn = wpAt; @(negedge clk);
    stopEvent = 0; wpIn = wpAfter;
    busyLen = 0; nWr = 0;
    while (busy === 1'b1 && busyLen < 1000) begin
      if (memWrEn === 1'b1 && nWr < 64) begin
        logAddr[nWr] = memWrAddr; logData[nWr] = memWrData; logCyc[nWr] = busyLen;
        nWr++;
      end
      if (inject) begin
        addrLoad = (busyLen == 5); startAddr = 13'h0500;
        byteValid = (busyLen == 5); byteData = 8'h99;
        stopEvent = (busyLen == 5);
      end
      busyLen++;
      @(negedge clk);
    end
    addrLoad = 0; byteValid = 0; stopEvent = 0; wpIn = 0;
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      chk({req, " busy idle"}, busy, 0);
      chk({req, " no write"}, memWrEn, 0);
      @(negedge clk);
    end
  endtask

  task automatic checkSlots(input string req, input int nWr);
    for (int i = 0; i < nWr; i++)
      chk({req, " slot timing"}, logCyc[i], int'(logAddr[i][4:0]));
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 memWrEn in reset", memWrEn, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 memWrEn after reset", memWrEn, 0);
  endtask

  task automatic testSingle();
    int bl, nw;
    loadAddr(13'h0123); sendByte(8'hA5);
    doStop(1'b0, 1'b1, 0, bl, nw);   // R6: wp raised right after STOP
    chk("R5 busy length", bl, BUSY_LEN);
    chk("R6 write count", nw, 1);
    chk("R4 addr", logAddr[0], 13'h0123);
    chk("R4 data", logData[0], 8'hA5);
    checkSlots("R4", nw);
  endtask

  task automatic testWrap();
    int bl, nw;
    loadAddr(13'h081E);
    wpIn = 1;                          // R6: wp high while collecting
    sendByte(8'h11); sendByte(8'h22); sendByte(8'h33); sendByte(8'h44);
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R6 wrap write count", nw, 4);
    chk("R2 wrap addr0", logAddr[0], 13'h0800);
    chk("R2 wrap data0", logData[0], 8'h33);
    chk("R2 wrap addr1", logAddr[1], 13'h0801);
    chk("R2 wrap data1", logData[1], 8'h44);
    chk("R2 wrap addr2", logAddr[2], 13'h081E);
    chk("R2 wrap data2", logData[2], 8'h11);
    chk("R2 wrap addr3", logAddr[3], 13'h081F);
    chk("R2 wrap data3", logData[3], 8'h22);
    checkSlots("R4", nw);
    chk("R5 busy length wrap", bl, BUSY_LEN);
  endtask

  task automatic testOverflow();
    int bl, nw;
    loadAddr(13'h1FE0);
    for (int i = 0; i < 34; i++) sendByte(8'(8'h40 + i));
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R3 write count", nw, 32);
    for (int s = 0; s < 32; s++) begin
      chk("R3 addr", logAddr[s], 13'h1FE0 + s);
      chk("R3 data", logData[s], (s < 2) ? 8'h60 + s : 8'h40 + s);
    end
  endtask

  task automatic testProtect();
    int bl, nw;
    loadAddr(13'h0200); sendByte(8'h01); sendByte(8'h02);
    doStop(1'b1, 1'b0, 0, bl, nw);
    chk("R7 protected busy", bl, 0);
    chk("R7 protected writes", nw, 0);
    loadAddr(13'h0205); sendByte(8'h77);
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R7 immediate accept writes", nw, 1);
    chk("R10 mask cleared addr", logAddr[0], 13'h0205);
    chk("R7 immediate accept data", logData[0], 8'h77);
  endtask

  task automatic testNoData();
    int bl, nw;
    loadAddr(13'h0300);
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R8 no-data busy", bl, 0);
    quiet("R8", 4);
  endtask

  task automatic testBusyIgnore();
    int bl, nw;
    loadAddr(13'h0400); sendByte(8'h5A);
    doStop(1'b0, 1'b0, 1, bl, nw);
    chk("R9 busy length with injection", bl, BUSY_LEN);
    chk("R9 write count", nw, 1);
    chk("R9 addr", logAddr[0], 13'h0400);
    sendByte(8'h11);
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R10 byte without transaction busy", bl, 0);
    quiet("R9", 4);
  endtask

  task automatic testRestart();
    int bl, nw;
    loadAddr(13'h0600); sendByte(8'h01); sendByte(8'h02);
    loadAddr(13'h0610); sendByte(8'h03);
    doStop(1'b0, 1'b0, 0, bl, nw);
    chk("R10 restart writes", nw, 1);
    chk("R10 restart addr", logAddr[0], 13'h0610);
    chk("R10 restart data", logData[0], 8'h03);
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSingle();
    testWrap();
    testOverflow();
    testProtect();
    testNoData();
    testBusyIgnore();
    testRestart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule